// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a single asynchronous serial line into parallel characters. The line is re-timed by a short flop chain. A prescale counter then produces an oversampling tick at sixteen times the bit rate. The tick period is set by an 8-bit divisor, so one bit lasts `16*(divisor+1)` clock cycles. A falling edge seen on a tick is checked again half a bit later. If it is still low, it is taken as a start bit, and every later bit is sampled once in the middle of its bit time.

Character length (7, 8 or 9 bits), parity (none, even, odd) and one or two stop bits are chosen on input pins. The pins are read live, so they must stay steady while a frame is in flight. When the last stop bit has been sampled, the assembled character moves into a holding buffer. At that point a one-cycle receive pulse is raised and the framing and parity flags are written.

If the buffer is still unread when the next frame reaches the bit just before its last stop bit, that frame is dropped. The buffer keeps the older character and the overrun flag is raised. A request-to-send style output goes low only while reception is enabled and the buffer is empty.

Top module: `serial_rx_core`

## Requirements
- R1: The serial input passes through a two-flop synchroniser. A low level seen on a tick in the idle state must still be low on the 8th following tick, or the start is abandoned and the receiver returns to idle.
- R2: A tick occurs every `divisor+1` clock cycles while enabled. Each bit after the start is sampled on every 16th tick, so a bit lasts `16*(divisor+1)` cycles.
- R3: `charLen` 0 selects 7 data bits, 2 selects 9, and 1 or 3 selects 8. Bits arrive LSB first, and `rxData` holds the character zero-extended to 9 bits.
- R4: `parityMode` 1 is even and 2 is odd; 0 and 3 mean no parity bit. The parity flag is set at transfer when the number of ones in the data plus the parity bit is odd (even mode) or even (odd mode).
- R5: `twoStop` 1 expects two stop bits and 0 expects one. The framing flag is set at transfer when any expected stop bit was sampled low.
- R6: At transfer, `rxFull` rises, `rxIrq` pulses high for exactly one cycle, and the framing and parity flags are written. The flags do not change at any other time.
- R7: If `rxFull` is 1 when the bit just before the last stop bit is sampled, the frame is discarded at its end. `overrunErr` goes to 1, `rxData` and the other flags keep their values, and no `rxIrq` is raised. A later successful transfer clears `overrunErr`.
- R8: `readStrobe` clears `rxFull` on the next edge. A transfer in the same cycle wins, and `rxFull` stays 1.
- R9: `errorSum` is 1 exactly when any of `overrunErr`, `framingErr` or `parityErr` is 1.
- R10: While `rxEnable` is 0, no frame is received, and a frame in flight is abandoned without a transfer. `rtsN` is 0 exactly when `rxEnable` is 1 and `rxFull` is 0.
- R11: After reset, `rxFull`, `rxIrq`, `rxData` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Reception enable |
| divisor | input | 8 | Tick divisor n; tick every n+1 cycles |
| charLen | input | 2 | Character length select |
| parityMode | input | 2 | Parity select |
| twoStop | input | 1 | Two stop bits when 1 |
| rxd | input | 1 | Asynchronous serial input, idle high |
| readStrobe | input | 1 | Consumer has taken the buffer |
| rxData | output | 9 | Holding buffer |
| rxFull | output | 1 | Buffer holds an unread character |
| rxIrq | output | 1 | One-cycle pulse on transfer |
| overrunErr | output | 1 | Overrun flag |
| framingErr | output | 1 | Framing flag |
| parityErr | output | 1 | Parity flag |
| errorSum | output | 1 | OR of the three error flags |
| rtsN | output | 1 | Low when ready to accept a character |

## Verification
The hardest case to reach is overrun. It depends on the buffer state at one particular sample deep inside the following frame, not on the state at the frame's end. The stimulus therefore sends back-to-back frames without reading, and then reads only after the pending overrun has latched. The expected outcome is a kept buffer and a raised flag but no pulse. Start-glitch rejection and disabling mid-frame are also driven on purpose. A behavioural model stepped every clock checks each output against its own timing.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int MAX_DATA_BITS = 9;
  localparam int IDX_W = $clog2(MAX_DATA_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rxState_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic             clearFrame;
    logic             dataTake;
    logic [IDX_W-1:0] bitIdx;
    logic             parTake;
    logic             stopTake;
    logic             preLastTake;
    logic             commit;
  } rxStrobes_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       charLen,
  input  logic [1:0]       parityMode,
  input  logic             twoStop,
  input  logic             rxs,
  output rxStrobes_t       strobes
);
  localparam int OS_W = $clog2(OSR);
  localparam logic [OS_W-1:0] MID_CNT  = OS_W'(OSR / 2 - 1);
  localparam logic [OS_W-1:0] LAST_CNT = OS_W'(OSR - 1);

  logic [DIV_W-1:0] preCnt;
  logic [OS_W-1:0]  osCnt;
  logic [IDX_W-1:0] bitCnt;
  logic [IDX_W-1:0] lastIdx;
  rxState_t         state, nextState;
  logic             tick, sampleNow, parOn, startDone;

  // tick generator
  assign tick = rxEnable && (preCnt == divisor);

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable || tick) preCnt <= '0;
    else                            preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    unique case (charLen)
      2'd0:    lastIdx = IDX_W'(6);
      2'd2:    lastIdx = IDX_W'(8);
      default: lastIdx = IDX_W'(7);
    endcase
  end

  assign parOn     = (parityMode == 2'd1) || (parityMode == 2'd2);
  assign sampleNow = tick && (osCnt == LAST_CNT);
  assign startDone = tick && (state == ST_START) && (osCnt == MID_CNT);

  always_comb begin
    nextState      = state;
    strobes        = '0;
    strobes.bitIdx = bitCnt;
    unique case (state)
      ST_IDLE: if (tick && !rxs) nextState = ST_START;
      ST_START: if (startDone) begin
        nextState          = rxs ? ST_IDLE : ST_DATA;
        strobes.clearFrame = !rxs;
      end
      ST_DATA: if (sampleNow) begin
        strobes.dataTake = 1'b1;
        if (bitCnt == lastIdx) nextState = parOn ? ST_PAR : ST_STOP1;
      end
      ST_PAR: if (sampleNow) begin
        strobes.parTake = 1'b1;
        nextState       = ST_STOP1;
      end
      ST_STOP1: if (sampleNow) begin
        strobes.stopTake = 1'b1;
        strobes.commit   = !twoStop;
        nextState        = twoStop ? ST_STOP2 : ST_IDLE;
      end
      ST_STOP2: if (sampleNow) begin
        strobes.stopTake = 1'b1;
        strobes.commit   = 1'b1;
        nextState        = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    // sample that leads into the last stop bit
    strobes.preLastTake = sampleNow && (state != nextState) &&
                          ((nextState == ST_STOP2) ||
                           (nextState == ST_STOP1 && !twoStop));
    if (!rxEnable) begin
      nextState = ST_IDLE;
      strobes   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      osCnt  <= '0;
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (!rxEnable)                         osCnt <= '0;
      else if (tick) begin
        if (state == ST_IDLE || startDone)   osCnt <= '0;
        else if (osCnt == LAST_CNT)          osCnt <= '0;
        else                                 osCnt <= osCnt + 1'b1;
      end
      if (strobes.clearFrame)    bitCnt <= '0;
      else if (strobes.dataTake) bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxd,
  input  logic [1:0]               parityMode,
  input  logic                     readStrobe,
  input  rxStrobes_t               strobes,
  output logic                     rxs,
  output logic [MAX_DATA_BITS-1:0] rxData,
  output logic                     rxFull,
  output logic                     rxIrq,
  output logic                     overrunErr,
  output logic                     framingErr,
  output logic                     parityErr
);
  logic [SYNC_STAGES-1:0]   syncQ;
  logic [MAX_DATA_BITS-1:0] shiftReg;
  logic parBit, stopBad, ovPend, stopBadNow, onesOdd, parityBad;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) syncQ <= !rstN ? '1 : rxd;
    end else begin : g_syncN
      always_ff @(posedge clk)
        syncQ <= !rstN ? '1 : {syncQ[SYNC_STAGES-2:0], rxd};
    end
  endgenerate
  assign rxs = syncQ[SYNC_STAGES-1];

  assign onesOdd    = ^{shiftReg, parBit};
  assign parityBad  = ((parityMode == 2'd1) && onesOdd) ||
                      ((parityMode == 2'd2) && !onesOdd);
  assign stopBadNow = stopBad || (strobes.stopTake && !rxs);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parBit     <= 1'b0;
      stopBad    <= 1'b0;
      ovPend     <= 1'b0;
      rxData     <= '0;
      rxFull     <= 1'b0;
      rxIrq      <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
    end else begin
      rxIrq <= 1'b0;
      if (strobes.clearFrame) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
        stopBad  <= 1'b0;
        ovPend   <= 1'b0;
      end
      if (strobes.dataTake)            shiftReg[strobes.bitIdx] <= rxs;
      if (strobes.parTake)             parBit  <= rxs;
      if (strobes.stopTake && !rxs)    stopBad <= 1'b1;
      if (strobes.preLastTake)         ovPend  <= rxFull;
      if (readStrobe)                  rxFull  <= 1'b0;
      if (strobes.commit) begin
        if (ovPend) overrunErr <= 1'b1;
        else begin
          rxData     <= shiftReg;
          rxFull     <= 1'b1;
          rxIrq      <= 1'b1;
          overrunErr <= 1'b0;
          framingErr <= stopBadNow;
          parityErr  <= parityBad;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic [DIV_W-1:0] divisor,
  input  logic [1:0]       charLen,
  input  logic [1:0]       parityMode,
  input  logic             twoStop,
  input  logic             rxd,
  input  logic             readStrobe,
  output logic [8:0]       rxData,
  output logic             rxFull,
  output logic             rxIrq,
  output logic             overrunErr,
  output logic             framingErr,
  output logic             parityErr,
  output logic             errorSum,
  output logic             rtsN
);
  rxStrobes_t strobes;
  logic       rxs;

  serial_rx_ctrl #(.DIV_W(DIV_W), .OSR(OSR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .divisor(divisor),
    .charLen(charLen), .parityMode(parityMode), .twoStop(twoStop),
    .rxs(rxs), .strobes(strobes)
  );

  serial_rx_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .rxd(rxd), .parityMode(parityMode),
    .readStrobe(readStrobe), .strobes(strobes), .rxs(rxs),
    .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq),
    .overrunErr(overrunErr), .framingErr(framingErr), .parityErr(parityErr)
  );

  assign errorSum = overrunErr | framingErr | parityErr;
  assign rtsN     = !(rxEnable && !rxFull);
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       readStrobe,
  input logic [8:0] rxData,
  input logic       rxFull,
  input logic       rxIrq,
  input logic       overrunErr,
  input logic       framingErr,
  input logic       parityErr
);
  p_irq_sets_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxFull);
  p_irq_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);
  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrq |-> ($stable(framingErr) && $stable(parityErr)));
  p_overrun_keeps_buf_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunErr) |-> ($stable(rxData) && !rxIrq));
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    readStrobe |=> (!rxFull || rxIrq));
  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxIrq);
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .readStrobe(readStrobe),
  .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq), .overrunErr(overrunErr),
  .framingErr(framingErr), .parityErr(parityErr)
);

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0;
  logic [7:0] divisor = 8'd3;
  logic [1:0] charLen = 2'd1;
  logic [1:0] parityMode = 2'd0;
  logic       twoStop = 1'b0;
  logic       rxd = 1'b1;
  logic       readStrobe = 1'b0;
  logic [8:0] rxData;
  logic rxFull, rxIrq, overrunErr, framingErr, parityErr, errorSum, rtsN;

  int nChecks = 0, nErrors = 0, irqCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  serial_rx_core u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .divisor(divisor),
    .charLen(charLen), .parityMode(parityMode), .twoStop(twoStop),
    .rxd(rxd), .readStrobe(readStrobe), .rxData(rxData), .rxFull(rxFull),
    .rxIrq(rxIrq), .overrunErr(overrunErr), .framingErr(framingErr),
    .parityErr(parityErr), .errorSum(errorSum), .rtsN(rtsN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  int mS1, mS2, mPre, mOs, mSt, mBit, mAcc, mPar, mBad, mPend;
  int mBuf, mFull, mIrq, mOv, mFe, mPe;

  always @(posedge clk) begin
    int nb, rxsNow, fullBefore, ones;
    bit parOn, tick, doCommit;
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPre = 0; mOs = 0; mSt = 0; mBit = 0; mAcc = 0;
      mPar = 0; mBad = 0; mPend = 0; mBuf = 0; mFull = 0; mIrq = 0;
      mOv = 0; mFe = 0; mPe = 0;
    end else begin
      mIrq = 0;
      doCommit = 0;
      rxsNow = mS2;
      nb = (charLen == 0) ? 7 : (charLen == 2) ? 9 : 8;
      parOn = (parityMode == 1) || (parityMode == 2);
      tick = rxEnable && (mPre == int'(divisor));
      mPre = (!rxEnable || tick) ? 0 : mPre + 1;
      fullBefore = mFull;
      if (readStrobe) mFull = 0;
      if (!rxEnable) begin
        mSt = 0; mOs = 0;
      end else if (tick) begin
        if (mSt == 0) begin
          if (rxsNow == 0) begin mSt = 1; mOs = 0; end
        end else if (mSt == 1) begin
          if (mOs == 7) begin
            mOs = 0;
            if (rxsNow == 0) begin
              mSt = 2; mBit = 0; mAcc = 0; mBad = 0; mPend = 0; mPar = 0;
            end else mSt = 0;
          end else mOs++;
        end else if (mOs != 15) mOs++;
        else begin
          mOs = 0;
          case (mSt)
            2: begin
              mAcc = mAcc | (rxsNow << mBit);
              mBit++;
              if (mBit == nb) begin
                mSt = parOn ? 3 : 4;
                if (!parOn && !twoStop) mPend = fullBefore;
              end
            end
            3: begin
              mPar = rxsNow; mSt = 4;
              if (!twoStop) mPend = fullBefore;
            end
            4: begin
              if (rxsNow == 0) mBad = 1;
              if (twoStop) begin mPend = fullBefore; mSt = 5; end
              else begin doCommit = 1; mSt = 0; end
            end
            default: begin
              if (rxsNow == 0) mBad = 1;
              doCommit = 1; mSt = 0;
            end
          endcase
        end
      end
      if (doCommit) begin
        if (mPend != 0) mOv = 1;
        else begin
          mBuf = mAcc; mFull = 1; mIrq = 1; mOv = 0; mFe = mBad;
          ones = $countones(mAcc) + mPar;
          mPe = ((parityMode == 1) && (ones % 2 == 1)) ||
                ((parityMode == 2) && (ones % 2 == 0));
        end
      end
      mS2 = mS1;
      mS1 = int'(rxd);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rxIrq) irqCount++;
      check(int'(rxData) == mBuf, "R3 rxData", rxData, mBuf);
      check(int'(rxFull) == mFull, "R8 rxFull", rxFull, mFull);
      check(int'(rxIrq) == mIrq, "R6 rxIrq", rxIrq, mIrq);
      check(int'(overrunErr) == mOv, "R7 overrunErr", overrunErr, mOv);
      check(int'(framingErr) == mFe, "R5 framingErr", framingErr, mFe);
      check(int'(parityErr) == mPe, "R4 parityErr", parityErr, mPe);
      check(errorSum == (mOv != 0 || mFe != 0 || mPe != 0), "R9 errorSum",
            errorSum, (mOv != 0 || mFe != 0 || mPe != 0));
      check(rtsN == !(rxEnable && mFull == 0), "R10 rtsN", rtsN,
            !(rxEnable && mFull == 0));
    end
  end

  task automatic hold(input bit v, input int cycles);
    rxd = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic sendFrame(input int data, input int nb, input bit flipPar,
                           input bit badStop1, input bit badStop2);
    int bp, ones;
    bit pb;
    bp = 16 * (int'(divisor) + 1);
    hold(1'b0, bp);
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      hold(data[i], bp);
      ones += data[i];
    end
    if (parityMode == 1 || parityMode == 2) begin
      pb = (parityMode == 1) ? (ones % 2 == 1) : (ones % 2 == 0);
      hold(pb ^ flipPar, bp);
    end
    hold(!badStop1, bp);
    if (twoStop) hold(!badStop2, bp);
    hold(1'b1, 2 * bp);
  endtask

  task automatic doRead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
      finish();
    end
  end

  initial begin
    int irqBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(rxData == 0 && !rxFull && !rxIrq, "R11 buffer reset", rxData, 0);
    check(!overrunErr && !framingErr && !parityErr, "R11 flags reset",
          {overrunErr, framingErr, parityErr}, 0);
    check(rtsN == 1'b1, "R10 rts with receive off", rtsN, 1);
    rxEnable = 1'b1;
    @(negedge clk);
    check(rtsN == 1'b0, "R10 rts ready", rtsN, 0);

    // R2 R3: 8N1, divisor 3
    sendFrame(9'h0A5, 8, 0, 0, 0);
    check(rxData == 9'h0A5 && rxFull, "R3 8-bit char", rxData, 9'h0A5);
    check(irqCount == 1, "R6 one pulse", irqCount, 1);
    doRead();
    check(!rxFull, "R8 read clears full", rxFull, 0);

    // R3 R4: 7 bits even parity
    charLen = 2'd0; parityMode = 2'd1;
    sendFrame(9'h0D5, 7, 0, 0, 0);
    check(rxData == 9'h055 && !parityErr, "R3 7-bit char", rxData, 9'h055);
    doRead();

    // R4: 9 bits odd parity, good then bad
    charLen = 2'd2; parityMode = 2'd2;
    sendFrame(9'h1C3, 9, 0, 0, 0);
    check(rxData == 9'h1C3 && !parityErr, "R4 odd ok", parityErr, 0);
    doRead();
    sendFrame(9'h1C3, 9, 1, 0, 0);
    check(parityErr && errorSum, "R4 odd bad", parityErr, 1);
    doRead();

    // R5: two stop bits, second one low
    charLen = 2'd3; parityMode = 2'd3; twoStop = 1'b1;
    sendFrame(9'h03C, 8, 0, 0, 1);
    check(framingErr && rxData == 9'h03C, "R5 second stop low", framingErr, 1);
    doRead();
    sendFrame(9'h081, 8, 0, 0, 0);
    check(!framingErr && !parityErr, "R6 flags rewritten", framingErr, 0);
    doRead();
    twoStop = 1'b0;
    sendFrame(9'h011, 8, 0, 1, 0);
    check(framingErr, "R5 single stop low", framingErr, 1);
    doRead();

    // R7: overrun, buffer kept, then cleared by a good transfer
    sendFrame(9'h061, 8, 0, 0, 0);
    irqBefore = irqCount;
    sendFrame(9'h09E, 8, 0, 0, 0);
    check(overrunErr && errorSum, "R7 overrun raised", overrunErr, 1);
    check(rxData == 9'h061, "R7 buffer kept", rxData, 9'h061);
    check(irqCount == irqBefore, "R7 no pulse", irqCount, irqBefore);
    doRead();
    sendFrame(9'h042, 8, 0, 0, 0);
    check(!overrunErr && rxData == 9'h042, "R7 overrun cleared", overrunErr, 0);
    doRead();

    // R1: short low pulse rejected
    irqBefore = irqCount;
    hold(1'b0, 3 * (int'(divisor) + 1));
    hold(1'b1, 40 * (int'(divisor) + 1) * 16 / 16 * 16);
    check(irqCount == irqBefore && !rxFull, "R1 glitch rejected", irqCount, irqBefore);

    // R10: disable mid-frame
    irqBefore = irqCount;
    hold(1'b0, 64);
    hold(1'b1, 64);
    rxEnable = 1'b0;
    hold(1'b1, 64 * 12);
    check(irqCount == irqBefore, "R10 frame abandoned", irqCount, irqBefore);
    rxEnable = 1'b1;
    hold(1'b1, 64);

    // R2: divisor 0
    divisor = 8'd0;
    sendFrame(9'h0F0, 8, 0, 0, 0);
    check(rxData == 9'h0F0 && rxFull, "R2 fastest rate", rxData, 9'h0F0);
    check(rtsN == 1'b1, "R10 rts when full", rtsN, 1);
    doRead();
    finish();
  end
endmodule